// File: doc/BRIEF.md
# Error-Injecting Manchester Word Transmitter

This block sends a message of serial-bus words on a three-state line drive. Each word is 20 bit periods long: a 3 µs sync, sixteen data bits sent most significant first, and an odd parity bit. The line is Manchester bi-phase coded at 1 Mbit/s. A test host fills a small word buffer and sets the message length. It then programs a set of deliberate faults and pulses `start`. The block plays the message out and pulses `done` when it has finished.

The faults are time-positioned on an internal half-bit time base of 500 ns, which is `TICK_DIV` clock cycles long. Two kinds of encoding error can be laid over any one word: a glitch, which forces the line idle, and an inversion, which swaps high and low. The other faults are:
- a bit-count change on one chosen word;
- a change to the number of words sent;
- a dead time between words.

Together these produce bad sync, parity and bi-phase faults on demand. All fault settings are captured when the message starts.

Top module: `manch_err_tx`

## Requirements
- R1: A word is 40 half-bits. Half-bits 0..5 are the sync. When the word's sync flag is 0 (command sync), half-bits 0..2 are high and 3..5 are low; when the flag is 1 (data sync), the order is reversed. Then come bits 0..15 from `wr_data[15]` down to `wr_data[0]`. A 1 is sent as high then low, and a 0 as low then high. High is `line_hi`=1/`line_lo`=0, low is 0/1, and idle is 0/0.
- R2: The bit after the sixteen data bits is a parity bit that makes the count of ones over the data and parity odd.
- R3: The word whose index equals `bc_word` carries `17 + bc_adj` bits after its sync (`bc_adj` is signed, −3..+3). Any bits beyond parity are logic 0. Bits are removed from the end, parity first.
- R4: The number of words sent is `msg_len + wc_adj` (`wc_adj` is signed, −32..+1). Word n reads buffer entry n mod DEPTH. If the count is zero or less, no word is sent, the line stays idle, and `done` pulses in the cycle after `start`.
- R5: `gap_sel` values 1, 2 and 3 put 2, 4 or 6 idle half-bits between consecutive words. These are the 1, 2 or 3 µs dead times. Value 0 sends the words back to back. No gap follows the last word.
- R6: With `err_mode`=1 (glitch), the line is idle during the error window.
- R7: With `err_mode`=2 (invert), high and low are swapped during the error window. `err_mode` values 0 and 3 disable the error.
- R8: The error window lies in word `err_word`. It covers half-bit positions from `err_start` up to `err_start` + min(`err_width`, 6), counted from the first sync half-bit of that word, and it is cut off at the end of that word.
- R9: `busy` rises in the cycle after an accepted `start`. Each half-bit lasts `TICK_DIV` cycles. `done` is a one-cycle pulse in the cycle after the last half-bit ends, and `busy` is low at the same time.
- R10: After reset `busy` and `done` are low and the line is idle. The line is always idle while `busy` is low.
- R11: While `busy` is high, `start` and changes to the message-length and fault inputs have no effect on the message in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | AW | Buffer entry to write |
| wr_data | input | 16 | Data bits of the word |
| wr_dsync | input | 1 | Sync flag of the word, 1 for data sync |
| msg_len | input | CW | Programmed word count |
| wc_adj | input | 6 | Signed word-count change |
| bc_word | input | CW | Index of the word that takes the bit-count change |
| bc_adj | input | 3 | Signed bit-count change |
| gap_sel | input | 2 | Dead time between words, in µs |
| err_mode | input | 2 | 0 off, 1 glitch, 2 invert, 3 off |
| err_word | input | CW | Index of the word that takes the encoding error |
| err_start | input | 6 | Error start, in half-bits |
| err_width | input | 3 | Error width, in half-bits (capped at 6) |
| start | input | 1 | Start pulse |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle end-of-message pulse |
| line_hi | output | 1 | Drive the line high |
| line_lo | output | 1 | Drive the line low |

## Verification
A wrong half-bit position or word index shows at the line within one half-bit. It appears as a misplaced sync edge, a wrong data or parity level, or an error window that starts or ends one slot off. A wrong word or gap counter leaves the message one or more half-bits too long or too short, so `done` comes early or late. The bench therefore checks every half-bit of each message against its own model, and it checks the exact cycle of `done`.

// File: rtl/manch_err_tx.sv
module manch_err_tx #(
  parameter int TICK_DIV = 4,
  parameter int DEPTH    = 8,
  parameter int AW       = $clog2(DEPTH),
  parameter int CW       = AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              wr_dsync,
  input  logic [CW-1:0]     msg_len,
  input  logic signed [5:0] wc_adj,
  input  logic [CW-1:0]     bc_word,
  input  logic signed [2:0] bc_adj,
  input  logic [1:0]        gap_sel,
  input  logic [1:0]        err_mode,
  input  logic [CW-1:0]     err_word,
  input  logic [5:0]        err_start,
  input  logic [2:0]        err_width,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              line_hi,
  output logic              line_lo
);
  localparam int DIVW = $clog2(TICK_DIV);

  logic [15:0] mem_d [DEPTH];
  logic        mem_s [DEPTH];

  always_ff @(posedge clk)
    if (wr_en) begin
      mem_d[wr_addr] <= wr_data;
      mem_s[wr_addr] <= wr_dsync;
    end

  logic [CW:0]        r_tot, widx;
  logic [CW-1:0]      r_bcw, r_ew;
  logic signed [2:0]  r_bca;
  logic [1:0]         r_gap, r_mode;
  logic [5:0]         r_es, hpos;
  logic [2:0]         r_wid, gcnt;
  logic               in_gap;
  logic [DIVW-1:0]    div;

  logic signed [CW+1:0] eff;
  assign eff = $signed({2'b00, msg_len}) + (CW+2)'(wc_adj);

  logic [5:0]  nh;
  logic [15:0] cur_d;
  logic        cur_s, bitv, lvl, drv, hit, glitch, inv;
  logic [4:0]  bidx;
  logic [2:0]  wid6;

  assign nh    = (widx == {1'b0, r_bcw}) ? 6'(7'd40 + {{3{r_bca[2]}}, r_bca, 1'b0}) : 6'd40;
  assign cur_d = mem_d[widx[AW-1:0]];
  assign cur_s = mem_s[widx[AW-1:0]];
  assign bidx  = 5'((hpos - 6'd6) >> 1);
  assign bitv  = (bidx < 5'd16) ? cur_d[4'd15 - bidx[3:0]] : (bidx == 5'd16) ? ~(^cur_d) : 1'b0;
  assign lvl   = (hpos < 6'd6) ? (cur_s ? (hpos >= 6'd3) : (hpos < 6'd3)) : (hpos[0] ? ~bitv : bitv);
  assign wid6  = (r_wid > 3'd6) ? 3'd6 : r_wid;
  assign hit   = (widx == {1'b0, r_ew}) && ({1'b0, hpos} >= {1'b0, r_es})
                 && ({1'b0, hpos} < {1'b0, r_es} + 7'(wid6));
  assign glitch = hit && (r_mode == 2'd1);
  assign inv    = hit && (r_mode == 2'd2);
  assign drv    = busy && !in_gap && !glitch;
  assign line_hi = drv && (lvl ^ inv);
  assign line_lo = drv && !(lvl ^ inv);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; in_gap <= 1'b0; div <= '0;
      widx <= '0; hpos <= '0; gcnt <= '0; r_tot <= '0;
      r_bcw <= '0; r_bca <= '0; r_gap <= '0; r_mode <= '0;
      r_ew <= '0; r_es <= '0; r_wid <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          r_tot <= eff[CW:0]; r_bcw <= bc_word; r_bca <= bc_adj; r_gap <= gap_sel;
          r_mode <= err_mode; r_ew <= err_word; r_es <= err_start; r_wid <= err_width;
          div <= '0; widx <= '0; hpos <= '0; in_gap <= 1'b0; gcnt <= '0;
          if (eff > 0) busy <= 1'b1;
          else done <= 1'b1;
        end
      end else if (div == DIVW'(TICK_DIV - 1)) begin
        div <= '0;
        if (in_gap) begin
          if (gcnt == 3'({r_gap, 1'b0} - 3'd1)) begin
            in_gap <= 1'b0; widx <= widx + 1'b1; hpos <= '0;
          end else gcnt <= gcnt + 3'd1;
        end else if (hpos == nh - 6'd1) begin
          if (widx == r_tot - 1'b1) begin
            busy <= 1'b0; done <= 1'b1;
          end else if (r_gap != 2'd0) begin
            in_gap <= 1'b1; gcnt <= '0;
          end else begin
            widx <= widx + 1'b1; hpos <= '0;
          end
        end else hpos <= hpos + 6'd1;
      end else div <= div + 1'b1;
    end

  AST_IDLE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!line_hi && !line_lo)); // R10
  AST_NO_DOUBLE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_hi && line_lo)); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_HALF_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && div != '0) |-> ($stable(line_hi) && $stable(line_lo))); // R1
  AST_BUSY_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R11
endmodule

// File: tb/manch_err_tx_test.sv
module manch_err_tx_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              wr_en = 1'b0, wr_dsync = 1'b0, start = 1'b0;
  logic [2:0]        wr_addr = '0;
  logic [15:0]       wr_data = '0;
  logic [4:0]        msg_len = '0, bc_word = '0, err_word = '0;
  logic signed [5:0] wc_adj = '0;
  logic signed [2:0] bc_adj = '0;
  logic [1:0]        gap_sel = '0, err_mode = '0;
  logic [5:0]        err_start = '0;
  logic [2:0]        err_width = '0;
  logic              busy, done, line_hi, line_lo;

  manch_err_tx uut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_dsync, .msg_len,
    .wc_adj, .bc_word, .bc_adj, .gap_sel, .err_mode, .err_word, .err_start, .err_width,
    .start, .busy, .done, .line_hi, .line_lo);

  int checks = 0, fails = 0;
  bit finished = 0;
  localparam logic [1:0] HI = 2'b10, LO = 2'b01, ID = 2'b00;
  logic [1:0] exp_sym [0:1023];
  int n_exp;

  // len, wc, bc_word, bc_adj, gap, mode, err_word, err_start, err_width, expected half-bits
  localparam int NV = 11;
  localparam int VEC [NV][10] = '{
    '{1,  0, 31,  0, 0, 0, 0,  0, 0,  40},
    '{3,  0, 31,  0, 0, 0, 0,  0, 0, 120},
    '{2,  0, 31,  0, 2, 0, 0,  0, 0,  84},
    '{2,  0,  1,  3, 0, 0, 0,  0, 0,  86},
    '{2,  0,  0, -3, 0, 0, 0,  0, 0,  74},
    '{2,  0, 31,  0, 0, 1, 0,  0, 6,  80},
    '{2,  0, 31,  0, 0, 2, 1, 38, 2,  80},
    '{3,  1, 31,  0, 0, 0, 0,  0, 0, 160},
    '{3, -1, 31,  0, 0, 0, 0,  0, 0,  80},
    '{2,  0, 31,  0, 3, 2, 0, 10, 7,  86},
    '{8,  1, 31,  0, 1, 3, 0,  0, 6, 376}};
  localparam string TAG [NV] = '{"R1 R2", "R1 R2", "R5", "R3", "R3", "R6 R8",
    "R7 R2", "R4", "R4", "R7 R8 R5", "R4 R5 R7"};

  function automatic logic [15:0] wd(int i); return 16'(i * 16'h1357 + 16'h8421); endfunction
  function automatic logic ws(int i); return (i % 2) == 1; endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic build(int v);
    int words, wid, base, nb;
    logic [15:0] d;
    logic b;
    n_exp = 0;
    words = VEC[v][0] + VEC[v][1];
    wid = (VEC[v][8] > 6) ? 6 : VEC[v][8];
    for (int w = 0; w < words; w++) begin
      d = wd(w % 8);
      base = n_exp;
      nb = 17 + ((w == VEC[v][2]) ? VEC[v][3] : 0);
      for (int s = 0; s < 6; s++) begin
        exp_sym[n_exp] = (ws(w % 8) ? (s >= 3) : (s < 3)) ? HI : LO;
        n_exp++;
      end
      for (int k = 0; k < nb; k++) begin
        b = (k < 16) ? d[15 - k] : (k == 16) ? ((^d) == 1'b0) : 1'b0;
        exp_sym[n_exp] = b ? HI : LO;
        exp_sym[n_exp + 1] = b ? LO : HI;
        n_exp += 2;
      end
      if ((VEC[v][5] == 1 || VEC[v][5] == 2) && w == VEC[v][6])
        for (int h = VEC[v][7]; h < VEC[v][7] + wid && h < n_exp - base; h++)
          exp_sym[base + h] = (VEC[v][5] == 1) ? ID : ~exp_sym[base + h];
      if (w < words - 1)
        for (int g = 0; g < 2 * VEC[v][4]; g++) begin
          exp_sym[n_exp] = ID;
          n_exp++;
        end
    end
  endtask

  task automatic run_vec(int v);
    int bad, first_bad, nexp;
    logic [1:0] got, firstv;
    build(v);
    nexp = VEC[v][9];
    msg_len = 5'(VEC[v][0]); wc_adj = 6'(VEC[v][1]); bc_word = 5'(VEC[v][2]);
    bc_adj = 3'(VEC[v][3]); gap_sel = 2'(VEC[v][4]); err_mode = 2'(VEC[v][5]);
    err_word = 5'(VEC[v][6]); err_start = 6'(VEC[v][7]); err_width = 3'(VEC[v][8]);
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    bad = 0; first_bad = -1; firstv = ID;
    for (int h = 0; h < nexp; h++) begin
      @(negedge clk);
      got = {line_hi, line_lo};
      if (h >= n_exp || got !== exp_sym[h]) begin
        if (bad == 0) begin first_bad = h; firstv = got; end
        bad++;
      end
      if (h < nexp - 1) repeat (3) @(negedge clk);
    end
    check(bad == 0, TAG[v], $sformatf("vector %0d line at half-bit %0d", v, first_bad),
          int'(firstv), (first_bad >= 0 && first_bad < n_exp) ? int'(exp_sym[first_bad]) : 0);
    repeat (2) @(negedge clk);
    check(done === 1'b0 && busy === 1'b1, "R9", $sformatf("vector %0d early end", v),
          int'({busy, done}), 2);
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R9", $sformatf("vector %0d done timing", v),
          int'({busy, done}), 1);
    @(negedge clk);
    check(done === 1'b0 && line_hi === 1'b0 && line_lo === 1'b0, "R10",
          $sformatf("vector %0d idle after done", v), int'({done, line_hi, line_lo}), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && line_hi === 1'b0 && line_lo === 1'b0,
          "R10", "reset state", int'({busy, done, line_hi, line_lo}), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(i); wr_data = wd(i); wr_dsync = ws(i);
    end
    @(negedge clk) wr_en = 1'b0;

    for (int v = 0; v < NV; v++) run_vec(v);

    // R4: a non-positive word count gives an immediate done and no traffic
    msg_len = 5'd3; wc_adj = -6'sd32; err_mode = 2'd0; gap_sel = 2'd0; bc_word = 5'd31;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(done === 1'b1 && busy === 1'b0 && line_hi === 1'b0 && line_lo === 1'b0, "R4",
          "empty message done pulse", int'({done, busy, line_hi, line_lo}), 8);
    @(negedge clk);
    check(done === 1'b0, "R4", "empty message done single", int'(done), 0);

    // R11: start and input changes while busy do not alter a one-word message
    msg_len = 5'd1; wc_adj = 6'sd0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy === 1'b1, "R9", "busy after start", int'(busy), 1);
    cyc = 1;
    repeat (20) @(negedge clk);
    cyc += 20;
    start = 1'b1; msg_len = 5'd5; gap_sel = 2'd3; err_mode = 2'd1; err_start = 6'd0; err_width = 3'd6;
    @(negedge clk) start = 1'b0;
    cyc++;
    while (done !== 1'b1 && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 161, "R11", "message length with start while busy", cyc, 161);
    @(negedge clk);
    check(busy === 1'b0 && line_hi === 1'b0 && line_lo === 1'b0, "R11",
          "no restart after done", int'({busy, line_hi, line_lo}), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule